// File: doc/BRIEF.md
# Overlap-Safe Rectangle Copy and Fill Engine

This block moves or paints rectangles of pixels inside a linear, byte-addressed framebuffer. The framebuffer geometry is given by a programmable line pitch (bytes from one scanline to the next) and a pixel size of one to four bytes. A copy command reads a `w`×`h` pixel rectangle at a source corner and writes it at a destination corner. A fill command paints a `w`×`h` rectangle with a constant colour.

The engine walks the rectangle one byte per memory access. It picks the scanline order, and the byte order within a scanline, so that a source and destination that overlap still produce the result of copying from an untouched snapshot of the source. Each command that finishes posts its destination rectangle into a 512-entry redraw queue. A display refresher drains that queue, and it can throw the whole queue away with a single discard pulse.

The engine has one command slot. A command is taken only while `busy` is low, and it is ignored otherwise.

Top module: `rect_copy_engine`

## Requirements
- R1: After reset, `busy`, `done`, `rq_valid`, `mem_rd_en` and `mem_wr_en` are all low.
- R2: The pixel at column x, row y starts at byte address `bpp*x + pitch*y`. Byte k of a pixel (k = 0 .. bpp-1) lies at that address plus k.
- R3: A copy writes exactly `bpp*w*h` bytes. Afterwards every destination byte holds the value that the matching source byte held before the command.
- R4: When the destination row is greater than the source row, scanlines are processed from the last row upward. Otherwise they are processed from the first row downward. In both cases, vertically overlapping copies give the snapshot result of R3.
- R5: When source and destination are on the same row and the destination column is greater, bytes within a scanline are moved from right to left. Otherwise they are moved from left to right. Horizontally overlapping copies on the same row therefore give the snapshot result.
- R6: A fill (`cmd_fill`=1) writes colour byte k, `cmd_color[8k+7:8k]`, into byte k of every pixel of the destination rectangle, and writes nothing outside it.
- R7: `busy` rises in the cycle after a command is accepted. `done` is high for exactly one cycle, the cycle right after the last memory write, and `busy` is low in the cycle after `done`.
- R8: `cmd_valid` while `busy` is high is ignored: no memory is touched for it and no rectangle is queued for it.
- R9: Every finished command pushes {dst_x, dst_y, w, h} into the redraw queue. `rq_valid` and the `rq_*` fields present the oldest entry, and `rq_pop` removes it.
- R10: The redraw queue holds 512 entries, and its read and write indices wrap modulo 512.
- R11: A `rq_discard` pulse makes the read index equal to the write index, which empties the queue. A push in the same cycle survives.
- R12: A command with w = 0 or h = 0 performs no memory access but still raises `done` and queues its rectangle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_stride | input | 16 | Bytes per scanline |
| cfg_bpp | input | 3 | Bytes per pixel, 1 to 4 |
| cmd_valid | input | 1 | Command request, taken while not busy |
| cmd_fill | input | 1 | 1 = solid fill, 0 = copy |
| cmd_src_x | input | 12 | Source column (copy only) |
| cmd_src_y | input | 12 | Source row (copy only) |
| cmd_dst_x | input | 12 | Destination column |
| cmd_dst_y | input | 12 | Destination row |
| cmd_w | input | 12 | Width in pixels |
| cmd_h | input | 12 | Height in rows |
| cmd_color | input | 32 | Fill colour, byte 0 in bits 7:0 |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Byte read request |
| mem_rd_addr | output | 24 | Read byte address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the request |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_wr_addr | output | 24 | Write byte address |
| mem_wr_data | output | 8 | Write data |
| rq_valid | output | 1 | Redraw queue is not empty |
| rq_x | output | 12 | Oldest queued rectangle, column |
| rq_y | output | 12 | Oldest queued rectangle, row |
| rq_w | output | 12 | Oldest queued rectangle, width |
| rq_h | output | 12 | Oldest queued rectangle, height |
| rq_pop | input | 1 | Remove the oldest entry |
| rq_discard | input | 1 | Drop every queued entry |

## Verification
The hardest case to reach from the ports is index wrap in the redraw queue. Reaching it takes more than 512 completed commands. The bench issues 600 one-pixel fills and pops after each, so the read and write indices both cross 511 while the head still has to match the command just issued. The overlap orderings are checked by filling memory with a position-dependent pattern before each copy. Any wrong row or byte order then reads an already-overwritten byte, and the whole memory image differs from the snapshot model.

// File: rtl/rce_pkg.sv
package rce_pkg;
    localparam int unsigned RCE_COORD_W = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } eng_state_e;

    typedef struct packed {
        logic [RCE_COORD_W-1:0] x;
        logic [RCE_COORD_W-1:0] y;
        logic [RCE_COORD_W-1:0] w;
        logic [RCE_COORD_W-1:0] h;
    } rect_t;
endpackage

// File: rtl/rce_redraw_queue.sv
module rce_redraw_queue
    import rce_pkg::*;
#(
    parameter int unsigned DEPTH = 512
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  rect_t push_rect,
    input  logic  pop,
    input  logic  discard,
    output logic  valid,
    output rect_t head
);
    localparam int unsigned IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [IDX_W-1:0] wr;
        logic [IDX_W-1:0] rd;
    } qidx_t;

    qidx_t idx_d, idx_q;
    rect_t slots [DEPTH];

    assign valid = (idx_q.rd != idx_q.wr);
    assign head  = slots[idx_q.rd];

    always_comb begin
        idx_d = idx_q;
        if (push) begin
            idx_d.wr = idx_q.wr + 1'b1;
        end
        if (discard) begin
            idx_d.rd = idx_q.wr;
        end else if (pop && valid) begin
            idx_d.rd = idx_q.rd + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slots[idx_q.wr] <= push_rect;
        end
    end
endmodule

// File: rtl/rce_walker.sv
module rce_walker
    import rce_pkg::*;
#(
    parameter int unsigned ADDR_W   = 24,
    parameter int unsigned STRIDE_W = 16,
    parameter int unsigned BPP_W    = 3,
    parameter int unsigned COLOR_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [STRIDE_W-1:0]    cfg_stride,
    input  logic [BPP_W-1:0]       cfg_bpp,
    input  logic                   cmd_valid,
    input  logic                   cmd_fill,
    input  logic [RCE_COORD_W-1:0] cmd_src_x,
    input  logic [RCE_COORD_W-1:0] cmd_src_y,
    input  logic [RCE_COORD_W-1:0] cmd_dst_x,
    input  logic [RCE_COORD_W-1:0] cmd_dst_y,
    input  logic [RCE_COORD_W-1:0] cmd_w,
    input  logic [RCE_COORD_W-1:0] cmd_h,
    input  logic [COLOR_W-1:0]     cmd_color,
    output logic                   busy,
    output logic                   done,
    output logic                   mem_rd_en,
    output logic [ADDR_W-1:0]      mem_rd_addr,
    input  logic [7:0]             mem_rd_data,
    output logic                   mem_wr_en,
    output logic [ADDR_W-1:0]      mem_wr_addr,
    output logic [7:0]             mem_wr_data,
    output logic                   push,
    output rect_t                  push_rect
);
    localparam int unsigned RB_W = RCE_COORD_W + BPP_W;

    typedef struct packed {
        eng_state_e             st;
        logic                   fill;
        logic                   up;
        logic                   rev;
        logic [ADDR_W-1:0]      src_row;
        logic [ADDR_W-1:0]      dst_row;
        logic [ADDR_W-1:0]      src_ptr;
        logic [ADDR_W-1:0]      dst_ptr;
        logic [RCE_COORD_W-1:0] rows_left;
        logic [RB_W-1:0]        bytes_left;
        logic [RB_W-1:0]        row_bytes;
        logic [BPP_W-1:0]       bpp;
        logic [BPP_W-1:0]       pix;
        logic [COLOR_W-1:0]     color;
        logic [STRIDE_W-1:0]    stride;
        rect_t                  rect;
    } walk_t;

    walk_t r_d, r_q;

    logic [RB_W-1:0]    rb_new;
    logic               up_new, rev_new;
    logic [ADDR_W-1:0]  yoff, s_base, d_base, inrow_new, inrow_cur;
    logic [ADDR_W-1:0]  src_nrow, dst_nrow;
    logic [COLOR_W-1:0] color_sh;
    logic               empty_cmd;

    assign busy      = (r_q.st != ST_IDLE);
    assign push_rect = r_q.rect;

    always_comb begin
        r_d         = r_q;
        done        = 1'b0;
        push        = 1'b0;
        mem_rd_en   = 1'b0;
        mem_wr_en   = 1'b0;
        mem_rd_addr = r_q.src_ptr;
        mem_wr_addr = r_q.dst_ptr;
        color_sh    = r_q.color >> (COLOR_W'(r_q.pix) * 8);
        mem_wr_data = r_q.fill ? color_sh[7:0] : mem_rd_data;

        // Command decode: direction choice and corner addresses
        rb_new    = RB_W'(cfg_bpp) * RB_W'(cmd_w);
        up_new    = !cmd_fill && (cmd_dst_y > cmd_src_y);
        rev_new   = !cmd_fill && (cmd_dst_y == cmd_src_y) && (cmd_dst_x > cmd_src_x);
        yoff      = up_new ? (ADDR_W'(cmd_h) - 1'b1) : '0;
        s_base    = ADDR_W'(cfg_bpp) * ADDR_W'(cmd_src_x)
                  + ADDR_W'(cfg_stride) * (ADDR_W'(cmd_src_y) + yoff);
        d_base    = ADDR_W'(cfg_bpp) * ADDR_W'(cmd_dst_x)
                  + ADDR_W'(cfg_stride) * (ADDR_W'(cmd_dst_y) + yoff);
        inrow_new = rev_new ? (ADDR_W'(rb_new) - 1'b1) : '0;
        empty_cmd = (cmd_w == '0) || (cmd_h == '0);

        // Row stepping for the running command
        inrow_cur = r_q.rev ? (ADDR_W'(r_q.row_bytes) - 1'b1) : '0;
        src_nrow  = r_q.up ? (r_q.src_row - ADDR_W'(r_q.stride))
                           : (r_q.src_row + ADDR_W'(r_q.stride));
        dst_nrow  = r_q.up ? (r_q.dst_row - ADDR_W'(r_q.stride))
                           : (r_q.dst_row + ADDR_W'(r_q.stride));

        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.fill       = cmd_fill;
                    r_d.up         = up_new;
                    r_d.rev        = rev_new;
                    r_d.src_row    = s_base;
                    r_d.dst_row    = d_base;
                    r_d.src_ptr    = s_base + inrow_new;
                    r_d.dst_ptr    = d_base + inrow_new;
                    r_d.rows_left  = cmd_h;
                    r_d.bytes_left = rb_new;
                    r_d.row_bytes  = rb_new;
                    r_d.bpp        = cfg_bpp;
                    r_d.pix        = '0;
                    r_d.color      = cmd_color;
                    r_d.stride     = cfg_stride;
                    r_d.rect       = '{x: cmd_dst_x, y: cmd_dst_y, w: cmd_w, h: cmd_h};
                    if (empty_cmd) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.st = cmd_fill ? ST_WRITE : ST_READ;
                    end
                end
            end
            ST_READ: begin
                mem_rd_en = 1'b1;
                r_d.st    = ST_WRITE;
            end
            ST_WRITE: begin
                mem_wr_en = 1'b1;
                r_d.st    = r_q.fill ? ST_WRITE : ST_READ;
                if (r_q.bytes_left == RB_W'(1)) begin
                    if (r_q.rows_left == RCE_COORD_W'(1)) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.rows_left  = r_q.rows_left - 1'b1;
                        r_d.src_row    = src_nrow;
                        r_d.dst_row    = dst_nrow;
                        r_d.src_ptr    = src_nrow + inrow_cur;
                        r_d.dst_ptr    = dst_nrow + inrow_cur;
                        r_d.bytes_left = r_q.row_bytes;
                        r_d.pix        = '0;
                    end
                end else begin
                    r_d.bytes_left = r_q.bytes_left - 1'b1;
                    r_d.src_ptr    = r_q.rev ? (r_q.src_ptr - 1'b1) : (r_q.src_ptr + 1'b1);
                    r_d.dst_ptr    = r_q.rev ? (r_q.dst_ptr - 1'b1) : (r_q.dst_ptr + 1'b1);
                    r_d.pix        = (r_q.pix == r_q.bpp - 1'b1) ? '0 : (r_q.pix + 1'b1);
                end
            end
            ST_DONE: begin
                done   = 1'b1;
                push   = 1'b1;
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/rect_copy_engine.sv
module rect_copy_engine
    import rce_pkg::*;
#(
    parameter int unsigned ADDR_W   = 24,
    parameter int unsigned STRIDE_W = 16,
    parameter int unsigned BPP_W    = 3,
    parameter int unsigned COLOR_W  = 32,
    parameter int unsigned Q_DEPTH  = 512
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [STRIDE_W-1:0]    cfg_stride,
    input  logic [BPP_W-1:0]       cfg_bpp,
    input  logic                   cmd_valid,
    input  logic                   cmd_fill,
    input  logic [RCE_COORD_W-1:0] cmd_src_x,
    input  logic [RCE_COORD_W-1:0] cmd_src_y,
    input  logic [RCE_COORD_W-1:0] cmd_dst_x,
    input  logic [RCE_COORD_W-1:0] cmd_dst_y,
    input  logic [RCE_COORD_W-1:0] cmd_w,
    input  logic [RCE_COORD_W-1:0] cmd_h,
    input  logic [COLOR_W-1:0]     cmd_color,
    output logic                   busy,
    output logic                   done,
    output logic                   mem_rd_en,
    output logic [ADDR_W-1:0]      mem_rd_addr,
    input  logic [7:0]             mem_rd_data,
    output logic                   mem_wr_en,
    output logic [ADDR_W-1:0]      mem_wr_addr,
    output logic [7:0]             mem_wr_data,
    output logic                   rq_valid,
    output logic [RCE_COORD_W-1:0] rq_x,
    output logic [RCE_COORD_W-1:0] rq_y,
    output logic [RCE_COORD_W-1:0] rq_w,
    output logic [RCE_COORD_W-1:0] rq_h,
    input  logic                   rq_pop,
    input  logic                   rq_discard
);
    logic  push;
    rect_t push_rect;
    rect_t head;

    rce_walker #(
        .ADDR_W  (ADDR_W),
        .STRIDE_W(STRIDE_W),
        .BPP_W   (BPP_W),
        .COLOR_W (COLOR_W)
    ) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_stride (cfg_stride),
        .cfg_bpp    (cfg_bpp),
        .cmd_valid  (cmd_valid),
        .cmd_fill   (cmd_fill),
        .cmd_src_x  (cmd_src_x),
        .cmd_src_y  (cmd_src_y),
        .cmd_dst_x  (cmd_dst_x),
        .cmd_dst_y  (cmd_dst_y),
        .cmd_w      (cmd_w),
        .cmd_h      (cmd_h),
        .cmd_color  (cmd_color),
        .busy       (busy),
        .done       (done),
        .mem_rd_en  (mem_rd_en),
        .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data),
        .mem_wr_en  (mem_wr_en),
        .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data),
        .push       (push),
        .push_rect  (push_rect)
    );

    rce_redraw_queue #(
        .DEPTH(Q_DEPTH)
    ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_rect(push_rect),
        .pop      (rq_pop),
        .discard  (rq_discard),
        .valid    (rq_valid),
        .head     (head)
    );

    assign rq_x = head.x;
    assign rq_y = head.y;
    assign rq_w = head.w;
    assign rq_h = head.h;
endmodule

// File: rtl/rce_checker.sv
module rce_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic mem_rd_en,
    input logic mem_wr_en,
    input logic rq_valid,
    input logic rq_discard
);
    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en));

    // R11
    discard_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_discard && !done) |=> !rq_valid);
endmodule

bind rect_copy_engine rce_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .rq_valid  (rq_valid),
    .rq_discard(rq_discard)
);

// File: tb/rect_copy_engine_tb.sv
module rect_copy_engine_tb;
    localparam int MEMSZ = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_stride = 16'd64;
    logic [2:0]  cfg_bpp = 3'd2;
    logic        cmd_valid = 1'b0, cmd_fill = 1'b0;
    logic [11:0] cmd_src_x = '0, cmd_src_y = '0, cmd_dst_x = '0, cmd_dst_y = '0;
    logic [11:0] cmd_w = '0, cmd_h = '0;
    logic [31:0] cmd_color = '0;
    logic        busy, done, mem_rd_en, mem_wr_en, rq_valid;
    logic [23:0] mem_rd_addr, mem_wr_addr;
    logic [7:0]  mem_rd_data, mem_wr_data;
    logic [11:0] rq_x, rq_y, rq_w, rq_h;
    logic        rq_pop = 1'b0, rq_discard = 1'b0;

    logic [7:0] mem  [MEMSZ];
    logic [7:0] snap [MEMSZ];
    logic [7:0] expm [MEMSZ];

    int nchk = 0;
    int nerr = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    rect_copy_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_stride(cfg_stride), .cfg_bpp(cfg_bpp),
        .cmd_valid(cmd_valid), .cmd_fill(cmd_fill),
        .cmd_src_x(cmd_src_x), .cmd_src_y(cmd_src_y),
        .cmd_dst_x(cmd_dst_x), .cmd_dst_y(cmd_dst_y),
        .cmd_w(cmd_w), .cmd_h(cmd_h), .cmd_color(cmd_color),
        .busy(busy), .done(done),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .rq_valid(rq_valid), .rq_x(rq_x), .rq_y(rq_y), .rq_w(rq_w), .rq_h(rq_h),
        .rq_pop(rq_pop), .rq_discard(rq_discard)
    );

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[11:0]];
        if (mem_wr_en) mem[mem_wr_addr[11:0]] <= mem_wr_data;
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            nchk = nchk + 1;
            nerr = nerr + 1;
            $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic init_mem();
        @(negedge clk);
        for (int i = 0; i < MEMSZ; i++) begin
            mem[i]  = 8'(i * 7 + 3);
            expm[i] = 8'(i * 7 + 3);
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        int first = 0;
        for (int i = MEMSZ - 1; i >= 0; i--) begin
            if (mem[i] !== expm[i]) begin
                bad++;
                first = i;
            end
        end
        chk(bad == 0, req, $sformatf("memory byte %0d", first), mem[first], expm[first]);
    endtask

    function automatic int paddr(input int x, input int y);
        return int'(cfg_bpp) * x + int'(cfg_stride) * y;
    endfunction

    // Expected copy: destination receives the pre-command source bytes
    task automatic model_copy(input int sx, sy, dx, dy, w, h);
        for (int i = 0; i < MEMSZ; i++) snap[i] = expm[i];
        for (int r = 0; r < h; r++)
            for (int b = 0; b < int'(cfg_bpp) * w; b++)
                expm[paddr(dx, dy + r) + b] = snap[paddr(sx, sy + r) + b];
    endtask

    task automatic model_fill(input int dx, dy, w, h, input logic [31:0] col);
        for (int r = 0; r < h; r++)
            for (int p = 0; p < w; p++)
                for (int k = 0; k < int'(cfg_bpp); k++)
                    expm[paddr(dx + p, dy + r) + k] = col[8*k +: 8];
    endtask

    // Issues one command and waits for completion; checks R7 timing.
    task automatic run_op(input bit fill, input int sx, sy, dx, dy, w, h,
                          input logic [31:0] col, input bit spam, output int nwr);
        bit prev_wr = 1'b0;
        bit seen = 1'b0;
        int cyc = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_fill = fill;
        cmd_src_x = 12'(sx); cmd_src_y = 12'(sy);
        cmd_dst_x = 12'(dx); cmd_dst_y = 12'(dy);
        cmd_w = 12'(w); cmd_h = 12'(h); cmd_color = col;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (spam) begin
            cmd_valid = 1'b1; cmd_fill = 1'b1;
            cmd_dst_x = 12'd0; cmd_dst_y = 12'd50;
            cmd_w = 12'd4; cmd_h = 12'd1; cmd_color = 32'hDEADBEEF;
        end
        chk(busy == 1'b1, "R7", "busy after accept", busy, 1);
        nwr = 0;
        while (!seen && cyc < 20000) begin
            if (done) begin
                seen = 1'b1;
                if (w != 0 && h != 0)
                    chk(prev_wr == 1'b1, "R7", "write in cycle before done", prev_wr, 1);
            end else begin
                if (mem_wr_en) nwr++;
                prev_wr = mem_wr_en;
                @(negedge clk);
                cyc++;
            end
        end
        cmd_valid = 1'b0;
        chk(seen, "R7", "done seen", seen, 1);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R7", "idle after done", {busy, done}, 0);
    endtask

    task automatic chk_head_pop(input int x, y, w, h, input string req);
        chk(rq_valid == 1'b1, req, "queue valid", rq_valid, 1);
        chk(rq_x == 12'(x) && rq_y == 12'(y), req, "queue head x*4096+y",
            rq_x * 4096 + rq_y, x * 4096 + y);
        chk(rq_w == 12'(w) && rq_h == 12'(h), req, "queue head w*4096+h",
            rq_w * 4096 + rq_h, w * 4096 + h);
        rq_pop = 1'b1;
        @(negedge clk);
        rq_pop = 1'b0;
    endtask

    task automatic t_reset();
        chk(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
        chk(rq_valid == 0, "R1", "queue empty after reset", rq_valid, 0);
        chk(mem_rd_en == 0 && mem_wr_en == 0, "R1", "no access after reset",
            {mem_rd_en, mem_wr_en}, 0);
    endtask

    task automatic t_addr();
        int n;
        init_mem();
        cfg_bpp = 3'd3; cfg_stride = 16'd40;
        model_fill(5, 2, 1, 1, 32'h00A1B2C3);
        run_op(1'b1, 0, 0, 5, 2, 1, 1, 32'h00A1B2C3, 1'b0, n);
        chk(mem[95] == 8'hC3 && mem[96] == 8'hB2 && mem[97] == 8'hA1, "R2",
            "pixel bytes at 95..97", {mem[95], mem[96], mem[97]}, 24'hC3B2A1);
        cmp_mem("R2");
        chk_head_pop(5, 2, 1, 1, "R9");
        cfg_bpp = 3'd2; cfg_stride = 16'd64;
    endtask

    task automatic t_fill();
        int n;
        init_mem();
        model_fill(3, 4, 5, 3, 32'h00001234);
        run_op(1'b1, 0, 0, 3, 4, 5, 3, 32'h00001234, 1'b0, n);
        chk(n == 30, "R6", "fill byte writes", n, 30);
        cmp_mem("R6");
        chk_head_pop(3, 4, 5, 3, "R9");
    endtask

    task automatic t_copy(input int sx, sy, dx, dy, w, h, input string req);
        int n;
        init_mem();
        model_copy(sx, sy, dx, dy, w, h);
        run_op(1'b0, sx, sy, dx, dy, w, h, 32'h0, 1'b0, n);
        chk(n == 2 * w * h, req, "copy byte writes", n, 2 * w * h);
        cmp_mem(req);
        chk_head_pop(dx, dy, w, h, "R9");
    endtask

    task automatic t_busy_ignore();
        int n;
        init_mem();
        model_copy(0, 0, 20, 10, 8, 4);
        run_op(1'b0, 0, 0, 20, 10, 8, 4, 32'h0, 1'b1, n);
        cmp_mem("R8");
        chk_head_pop(20, 10, 8, 4, "R8");
        chk(rq_valid == 1'b0, "R8", "no entry for ignored command", rq_valid, 0);
    endtask

    task automatic t_zero();
        int n;
        init_mem();
        run_op(1'b1, 0, 0, 7, 7, 0, 3, 32'hFFFFFFFF, 1'b0, n);
        chk(n == 0, "R12", "writes for zero width", n, 0);
        cmp_mem("R12");
        chk_head_pop(7, 7, 0, 3, "R12");
    endtask

    task automatic t_discard();
        int n;
        init_mem();
        run_op(1'b1, 0, 0, 1, 1, 0, 1, 32'h0, 1'b0, n);
        run_op(1'b1, 0, 0, 2, 2, 0, 1, 32'h0, 1'b0, n);
        chk(rq_valid == 1'b1 && rq_x == 12'd1, "R9", "oldest entry first", rq_x, 1);
        rq_discard = 1'b1;
        @(negedge clk);
        rq_discard = 1'b0;
        chk(rq_valid == 1'b0, "R11", "queue empty after discard", rq_valid, 0);
    endtask

    task automatic t_wrap();
        int n;
        int bad = 0;
        for (int i = 0; i < 600; i++) begin
            run_op(1'b1, 0, 0, i % 16, 60, 1, 1, 32'h5A5A, 1'b0, n);
            if (!(rq_valid && rq_x == 12'(i % 16) && rq_y == 12'd60)) bad++;
            rq_pop = 1'b1;
            @(negedge clk);
            rq_pop = 1'b0;
        end
        chk(bad == 0, "R10", "heads across index wrap", bad, 0);
        chk(rq_valid == 1'b0, "R10", "empty after 600 push/pop", rq_valid, 0);
    endtask

    initial begin
        for (int i = 0; i < MEMSZ; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr();
        t_fill();
        t_copy(0, 0, 10, 20, 6, 4, "R3");
        t_copy(2, 5, 3, 7, 8, 5, "R4");
        t_copy(4, 10, 2, 8, 8, 5, "R4");
        t_copy(1, 30, 4, 30, 10, 2, "R5");
        t_copy(6, 33, 2, 33, 10, 2, "R5");
        t_busy_ignore();
        t_zero();
        t_discard();
        t_wrap();
        summary();
    end
endmodule